// File: doc/BRIEF.md
# Lockable SMRAM Access Controller

This block holds one byte-wide configuration register and uses it to steer memory accesses aimed at the 128 KB legacy system-management window at 0xA0000–0xBFFFF. Each access carries an address, an SMM-active flag and a flag that marks it as a code fetch. The block raises exactly one of two outputs for each access. One output sends the access to the DRAM behind the window. The other forwards it to the downstream hub. The window is only made visible; its addresses are never remapped.

Firmware first sets the global enable. It can then use the open bit to reach the window from outside SMM and fill it. After that it sets the lock, which clears the open bit and freezes the enable, open and lock fields until the next full reset. While SMM is active, the close bit lets code fetches reach the window while data references fall through to the hub. A warm reset leaves the register untouched and only blocks configuration writes while it is held.

Top module: `smram_gate`

## Requirements
- R1: After a full reset, a read at configuration offset 0x9D returns 0x02, and a read at any other offset returns 0x00.
- R2: Read data bit 7 is always 0 and bits 2:0 always read 3'b010, whatever value is written.
- R3: While the global enable (bit 3) is 0, every access goes to the hub, whatever the open and close bits and the SMM flag are. A write with bit 3 equal to 0 cannot set the lock (bit 4).
- R4: With the global enable set and close (bit 5) clear, an access inside the window with SMM active goes to DRAM.
- R5: With the enable set, an access inside the window without SMM goes to DRAM when open (bit 6) is 1 and lock is 0. It goes to the hub when open is 0.
- R6: With close set and SMM active, data accesses inside the window go to the hub and code fetches go to DRAM.
- R7: With both open and close set, every access outside SMM that falls inside the window goes to DRAM. Inside SMM, data accesses go to the hub and code fetches go to DRAM.
- R8: The write that sets the lock forces open to 0. After that, writes leave bits 6, 4 and 3 unchanged, while the close bit stays writable.
- R9: Only a full reset clears the register, including the lock. A warm reset leaves the contents unchanged, and configuration writes made while warm reset is asserted are ignored.
- R10: An address below 0xA0000 or at or above 0xC0000 goes to the hub. For every access, exactly one of the two route outputs is 1.
- R11: A write to any offset other than 0x9D leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| full_rst_n | input | 1 | Full reset, active low. Asserts asynchronously and is released synchronously |
| warm_rst_n | input | 1 | Warm reset, active low. Blocks configuration writes and keeps register contents |
| cfg_addr | input | 8 | Configuration offset for a read or write |
| cfg_wr | input | 1 | Configuration write strobe, sampled on the rising clock edge |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| acc_addr | input | 32 | Memory access address |
| acc_smm | input | 1 | Access is made while SMM is active |
| acc_code | input | 1 | Access is a code fetch (0 marks a data reference) |
| route_dram | output | 1 | Access goes to the DRAM window |
| route_hub | output | 1 | Access is forwarded to the hub |

## Verification
The routing decision is tried with every mix of SMM flag and code/data flag under each register setting: disabled, enabled alone, open, close, and open with close. This separates the close rule, which applies only to data inside SMM, from the open rule, which applies only outside SMM. Address probes on both sides of each window boundary, plus an alias one bit above, show that the compare uses the full address. Write sequences before and after the lock, under warm reset, and to neighbouring offsets show which fields freeze and what each kind of reset clears.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int BIT_OPEN  = 6;
  localparam int BIT_CLOSE = 5;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_GEN   = 3;
  localparam logic [2:0] SEG_CODE = 3'b010;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic gen;
  } smram_ctl_t;
endpackage

// File: rtl/smram_rst_sync.sv
module smram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output smram_ctl_t ctl
);
  smram_ctl_t ctl_q, ctl_d;
  logic       ld_en;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[7], wdata[2:0]};
  assign ld_en = wr_en;

  always_comb begin
    ctl_d       = ctl_q;
    ctl_d.close = wdata[BIT_CLOSE];
    if (!ctl_q.lock) begin
      ctl_d.gen  = wdata[BIT_GEN];
      ctl_d.lock = wdata[BIT_LOCK] & wdata[BIT_GEN];
      ctl_d.open = wdata[BIT_OPEN] & ~ctl_d.lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (ld_en) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
  import smram_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  smram_ctl_t        ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic              code,
  output logic              to_dram,
  output logic              to_hub
);
  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + WIN_SIZE;

  logic in_win;
  logic smm_ok;
  logic open_ok;

  always_comb begin
    in_win  = (addr >= WIN_BASE) && (addr < WIN_END);
    smm_ok  = smm & (code | ~ctl.close);
    open_ok = ~smm & ctl.open & ~ctl.lock;
    to_dram = ctl.gen & in_win & (smm_ok | open_ok);
    to_hub  = ~to_dram;
  end
endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smram_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                CFG_AW     = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h9D,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE   = 'h20000,
  parameter int                SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              full_rst_n,
  input  logic              warm_rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_code,
  output logic              route_dram,
  output logic              route_hub
);
  logic       rst_sync_n;
  logic       cfg_hit;
  logic       cfg_we;
  smram_ctl_t ctl;

  smram_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .arst_n (full_rst_n),
    .srst_n (rst_sync_n)
  );

  assign cfg_hit = (cfg_addr == CFG_OFFSET);
  assign cfg_we  = cfg_wr & cfg_hit & warm_rst_n;

  smram_cfg_reg u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (cfg_we),
    .wdata (cfg_wdata),
    .ctl   (ctl)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_hit) begin
      cfg_rdata[BIT_OPEN]  = ctl.open;
      cfg_rdata[BIT_CLOSE] = ctl.close;
      cfg_rdata[BIT_LOCK]  = ctl.lock;
      cfg_rdata[BIT_GEN]   = ctl.gen;
      cfg_rdata[2:0]       = SEG_CODE;
    end
  end

  smram_route_dec #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_dec (
    .ctl     (ctl),
    .addr    (acc_addr),
    .smm     (acc_smm),
    .code    (acc_code),
    .to_dram (route_dram),
    .to_hub  (route_hub)
  );
endmodule

// File: rtl/smram_gate_chk.sv
module smram_gate_chk #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst_n,
  input logic              cfg_wr,
  input logic              cfg_hit,
  input logic [3:0]        ctl_bits,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              route_dram,
  input logic              route_hub
);
  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + WIN_SIZE;

  logic c_open, c_lock, c_gen;
  logic outside;
  assign c_open  = ctl_bits[3];
  assign c_lock  = ctl_bits[1];
  assign c_gen   = ctl_bits[0];
  assign outside = (acc_addr < WIN_BASE) || (acc_addr >= WIN_END);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_lock |=> c_lock);

  // R8
  lock_clears_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_lock |-> !c_open);

  // R8
  lock_freezes_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_lock |=> $stable(c_gen));

  // R3
  lock_needs_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_lock |-> c_gen);

  // R3
  disabled_to_hub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_gen |-> (route_hub && !route_dram));

  // R10
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({route_dram, route_hub}) == 1);

  // R10
  outside_to_hub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> route_hub);

  // R9
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst_n |=> $stable(ctl_bits));

  // R11
  other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_hit) |=> $stable(ctl_bits));
endmodule

bind smram_gate smram_gate_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BASE (WIN_BASE),
  .WIN_SIZE (WIN_SIZE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .warm_rst_n (warm_rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_hit    (cfg_hit),
  .ctl_bits   (ctl),
  .acc_addr   (acc_addr),
  .route_dram (route_dram),
  .route_hub  (route_hub)
);

// File: tb/smram_gate_tb.sv
module smram_gate_tb;
  logic        clk;
  logic        full_rst_n;
  logic        warm_rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_wr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [31:0] acc_addr;
  logic        acc_smm;
  logic        acc_code;
  logic        route_dram;
  logic        route_hub;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  smram_gate u_dut (
    .clk        (clk),
    .full_rst_n (full_rst_n),
    .warm_rst_n (warm_rst_n),
    .cfg_addr   (cfg_addr),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .acc_addr   (acc_addr),
    .acc_smm    (acc_smm),
    .acc_code   (acc_code),
    .route_dram (route_dram),
    .route_hub  (route_hub)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_full_reset();
    @(negedge clk);
    full_rst_n = 0;
    repeat (2) @(negedge clk);
    full_rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_addr = 8'h9D;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk8(req, cfg_rdata, exp);
    cfg_addr = 8'h9D;
  endtask

  task automatic route(string req, logic [31:0] a, logic smm, logic code, logic exp_dram);
    acc_addr = a; acc_smm = smm; acc_code = code;
    #1;
    chk8(req, {6'd0, route_dram, route_hub}, {6'd0, exp_dram, ~exp_dram});
  endtask

  task automatic t_reset();
    do_full_reset();
    rd("R1 reset value", 8'h9D, 8'h02);
    rd("R1 other offset", 8'h9C, 8'h00);
    route("R3 reset routes to hub", 32'hA0000, 1, 0, 0);
  endtask

  task automatic t_readonly();
    do_full_reset();
    wr(8'h9D, 8'hE5);
    rd("R2 fixed bits", 8'h9D, 8'h62);
  endtask

  task automatic t_disabled();
    do_full_reset();
    wr(8'h9D, 8'h60);
    rd("R3 open+close without enable", 8'h9D, 8'h62);
    route("R3 off non-SMM", 32'hA8000, 0, 0, 0);
    route("R3 off SMM code", 32'hA8000, 1, 1, 0);
    route("R3 off SMM data", 32'hA8000, 1, 0, 0);
    wr(8'h9D, 8'h50);
    rd("R3 lock refused without enable", 8'h9D, 8'h42);
    route("R3 off open", 32'hB0000, 0, 0, 0);
  endtask

  task automatic t_smm_basic();
    do_full_reset();
    wr(8'h9D, 8'h08);
    route("R4 SMM data", 32'hA0000, 1, 0, 1);
    route("R4 SMM code", 32'hBFFFF, 1, 1, 1);
    route("R5 non-SMM closed window", 32'hA0000, 0, 0, 0);
  endtask

  task automatic t_open();
    do_full_reset();
    wr(8'h9D, 8'h48);
    route("R5 open non-SMM data", 32'hB0000, 0, 0, 1);
    route("R5 open non-SMM code", 32'hB0000, 0, 1, 1);
    wr(8'h9D, 8'h08);
    route("R5 reclosed non-SMM", 32'hB0000, 0, 0, 0);
  endtask

  task automatic t_close();
    do_full_reset();
    wr(8'h9D, 8'h28);
    route("R6 close SMM data", 32'hA4000, 1, 0, 0);
    route("R6 close SMM code", 32'hA4000, 1, 1, 1);
    route("R6 close non-SMM", 32'hA4000, 0, 1, 0);
  endtask

  task automatic t_open_close();
    do_full_reset();
    wr(8'h9D, 8'h68);
    route("R7 non-SMM data", 32'hA2000, 0, 0, 1);
    route("R7 non-SMM code", 32'hA2000, 0, 1, 1);
    route("R7 SMM data", 32'hA2000, 1, 0, 0);
    route("R7 SMM code", 32'hA2000, 1, 1, 1);
  endtask

  task automatic t_lock();
    do_full_reset();
    wr(8'h9D, 8'h48);
    wr(8'h9D, 8'h58);
    rd("R8 lock clears open", 8'h9D, 8'h1A);
    route("R8 locked non-SMM", 32'hA0000, 0, 0, 0);
    wr(8'h9D, 8'h00);
    rd("R8 enable and lock frozen", 8'h9D, 8'h1A);
    route("R8 locked SMM data", 32'hA0000, 1, 0, 1);
    wr(8'h9D, 8'h20);
    rd("R8 close still writable", 8'h9D, 8'h3A);
    wr(8'h9D, 8'h40);
    rd("R8 open not writable", 8'h9D, 8'h1A);
    route("R8 open write no effect", 32'hA0000, 0, 0, 0);
  endtask

  task automatic t_warm_full();
    do_full_reset();
    wr(8'h9D, 8'h18);
    rd("R9 locked", 8'h9D, 8'h1A);
    @(negedge clk);
    warm_rst_n = 0;
    repeat (3) @(negedge clk);
    rd("R9 warm keeps lock", 8'h9D, 8'h1A);
    wr(8'h9D, 8'h28);
    rd("R9 write during warm ignored", 8'h9D, 8'h1A);
    warm_rst_n = 1;
    do_full_reset();
    rd("R9 full reset clears", 8'h9D, 8'h02);
    wr(8'h9D, 8'h08);
    rd("R9 writable after full reset", 8'h9D, 8'h0A);
  endtask

  task automatic t_edges();
    do_full_reset();
    wr(8'h9D, 8'h08);
    route("R10 below base", 32'h0009FFFF, 1, 0, 0);
    route("R10 base", 32'h000A0000, 1, 0, 1);
    route("R10 top", 32'h000BFFFF, 1, 0, 1);
    route("R10 end", 32'h000C0000, 1, 0, 0);
    route("R10 alias", 32'h001A0000, 1, 0, 0);
  endtask

  task automatic t_other_offset();
    do_full_reset();
    wr(8'h9C, 8'h08);
    wr(8'h9E, 8'h48);
    rd("R11 untouched", 8'h9D, 8'h02);
    route("R11 still disabled", 32'hA0000, 1, 0, 0);
  endtask

  initial begin
    full_rst_n = 0; warm_rst_n = 1;
    cfg_addr = 8'h9D; cfg_wr = 0; cfg_wdata = 0;
    acc_addr = 0; acc_smm = 0; acc_code = 0;
    t_reset();
    t_readonly();
    t_disabled();
    t_smm_basic();
    t_open();
    t_close();
    t_open_close();
    t_lock();
    t_warm_full();
    t_edges();
    t_other_offset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule